// File: doc/BRIEF.md
# Staggered Multi-Channel RGB PWM Generator

This block produces the on/off gate signals for twelve LED current sinks, arranged as four sets of red, green and blue. Each channel carries a 6-bit duty code that selects how many of the 63 steps in a PWM period the sink conducts. Each channel also has a 2-bit amplitude code that the block passes straight through to its sink. A programmable divider turns the system clock into a step tick. The tick rate is set by a 2-bit frequency select, so the PWM period can be long, medium or short.

The three colours in a set place their pulses differently. Red opens at the start of the period, green is centred on the middle of the period, and blue closes at the end. The four sets run their periods at staggered offsets, so switch-on edges from different sets do not land on the same step.

A set drives its outputs only when its own enable and the global device enable are both high. A global force-off input blanks every output at once, for example while the supply is starting up. Duty codes are captured at each set's own period boundary, so a register write in the middle of a period never produces a shortened or split pulse.

Top module: `rgb_pwm_stagger`

## Requirements
- R1: While reset is asserted, all twelve gate outputs are 0, whatever the other inputs are.
- R2: A channel with duty code N is on for exactly N of the 63 steps of its period. Code 0 is never on and code 63 is always on.
- R3: Red, which is colour index 0 in a set, is on at local phase p when p < N.
- R4: Green, which is colour index 1, is on when S <= p < S+N, where S = floor((63-N)/2).
- R5: Blue, which is colour index 2, is on when p >= 63-N.
- R6: A global step counter g starts at 0 when the device enable rises and counts 0..62, wrapping back to 0. Set k, for k = 0..3, uses local phase p = (g - 16k) mod 63. Channel index is 3k + colour. Duty code of channel i sits at duty_in[6i+5:6i], and its gate is gate_out[i].
- R7: One step lasts STEP_DIV system clocks for frequency select 00, STEP_DIV/2 clocks for 01, and STEP_DIV/4 clocks for 10. Select 11 behaves exactly like 10.
- R8: The three gates of set k are 0 whenever set_en[k] is 0 or dev_en is 0. The change appears in the same cycle as the input.
- R9: A set captures its duty codes on the step that ends its local period, which is local phase 62. A duty change made during a period takes effect in the next period. While the set or the device is disabled, the codes are captured continuously.
- R10: force_off high makes all gate outputs 0 in the same cycle.
- R11: lvl_out always equals lvl_in. Channel i's amplitude code is at bits [2i+1:2i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_en | input | 1 | Global device enable; low holds the step timer at step 0 |
| set_en | input | 4 | Per-set enables |
| fsel | input | 2 | PWM frequency select |
| force_off | input | 1 | Blanks all gates immediately |
| duty_in | input | 72 | Twelve 6-bit duty codes |
| lvl_in | input | 24 | Twelve 2-bit amplitude codes |
| gate_out | output | 12 | Sink on/off gates |
| lvl_out | output | 24 | Amplitude codes forwarded to the sinks |

## Verification
The gating inputs act combinationally, so after a change to set_en, dev_en or force_off the bench samples 1 ns later in the same cycle. The step counter moves one step after STEP_DIV>>shift rising edges. The bench therefore drives dev_en at a falling edge, treats that moment as step 0, and samples a fixed 1 ns after each falling edge. It then advances exactly one step length in falling edges, so each sample falls in the middle of a known step. A duty write is checked against the old window for the rest of the current period and against the new window over the whole following period. This follows from the capture register that loads on the phase-62 tick.

// File: rtl/rgb_pwm_pkg.sv
package rgb_pwm_pkg;

   typedef enum logic [1:0] {
      ALIGN_START  = 2'd0,
      ALIGN_CENTRE = 2'd1,
      ALIGN_END    = 2'd2
   } align_e;

   // number of right shifts applied to the slow step divider
   function automatic logic [1:0] fsel_shift(input logic [1:0] sel);
      if (sel[1])      return 2'd2;
      else if (sel[0]) return 2'd1;
      else             return 2'd0;
   endfunction

endpackage

// File: rtl/pwm_step_timer.sv
module pwm_step_timer #(
   parameter int STEP_DIV = 80,
   parameter int STEP_W   = 6,
   parameter int STEPS    = 63
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dev_en,
   input  logic [1:0]        fsel,
   output logic              tick,
   output logic [STEP_W-1:0] step
);
   localparam int DIV_W = $clog2(STEP_DIV + 1);

   logic [DIV_W-1:0] div_cnt;
   logic [DIV_W-1:0] lim_m1;

   always_comb begin
      lim_m1 = DIV_W'((STEP_DIV >> rgb_pwm_pkg::fsel_shift(fsel)) - 1);
      tick   = dev_en && (div_cnt >= lim_m1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_cnt <= '0;
         step    <= '0;
      end else if (!dev_en) begin
         div_cnt <= '0;
         step    <= '0;
      end else if (tick) begin
         div_cnt <= '0;
         step    <= (step == STEP_W'(STEPS - 1)) ? '0 : step + 1'b1;
      end else begin
         div_cnt <= div_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
   import rgb_pwm_pkg::*;
#(
   parameter align_e ALIGN  = ALIGN_START,
   parameter int     DUTY_W = 6,
   parameter int     STEPS  = 63
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DUTY_W-1:0] duty_in,
   input  logic [DUTY_W-1:0] phase,
   output logic              on
);
   localparam int W1 = DUTY_W + 1;

   logic [DUTY_W-1:0] duty_q;
   logic [W1-1:0]     ph_x;
   logic [W1-1:0]     dq_x;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    duty_q <= '0;
      else if (load) duty_q <= duty_in;
   end

   assign ph_x = {1'b0, phase};
   assign dq_x = {1'b0, duty_q};

   generate
      if (ALIGN == ALIGN_START) begin : g_start
         assign on = ph_x < dq_x;
      end else if (ALIGN == ALIGN_CENTRE) begin : g_centre
         logic [W1-1:0] first;
         logic [W1-1:0] last;
         assign first = (W1'(STEPS) - dq_x) >> 1;
         assign last  = first + dq_x;
         assign on    = (ph_x >= first) && (ph_x < last);
      end else begin : g_end
         assign on = ph_x >= (W1'(STEPS) - dq_x);
      end
   endgenerate
endmodule

// File: rtl/pwm_set.sv
module pwm_set
   import rgb_pwm_pkg::*;
#(
   parameter int IDX        = 0,
   parameter int DUTY_W     = 6,
   parameter int STEPS      = 63,
   parameter int SET_OFFSET = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                dev_en,
   input  logic                set_en,
   input  logic                force_off,
   input  logic                tick,
   input  logic [DUTY_W-1:0]   step,
   input  logic [3*DUTY_W-1:0] duty_in,
   output logic [2:0]          gate
);
   localparam int OFF = (IDX * SET_OFFSET) % STEPS;

   logic [DUTY_W-1:0] phase;
   logic              load;
   logic              active;
   logic [2:0]        raw_on;

   generate
      if (OFF == 0) begin : g_nooff
         assign phase = step;
      end else begin : g_off
         assign phase = (step >= DUTY_W'(OFF)) ? step - DUTY_W'(OFF)
                                               : step + DUTY_W'(STEPS - OFF);
      end
   endgenerate

   assign load   = !dev_en || !set_en || (tick && (phase == DUTY_W'(STEPS - 1)));
   assign active = dev_en && set_en && !force_off;

   generate
      for (genvar c = 0; c < 3; c++) begin : g_col
         pwm_chan #(
            .ALIGN  (align_e'(c)),
            .DUTY_W (DUTY_W),
            .STEPS  (STEPS)
         ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load),
            .duty_in (duty_in[c*DUTY_W +: DUTY_W]),
            .phase   (phase),
            .on      (raw_on[c])
         );
      end
   endgenerate

   assign gate = active ? raw_on : 3'b000;
endmodule

// File: rtl/rgb_pwm_stagger.sv
module rgb_pwm_stagger #(
   parameter int NUM_SETS   = 4,
   parameter int DUTY_W     = 6,
   parameter int LVL_W      = 2,
   parameter int SET_OFFSET = 16,
   parameter int STEP_DIV   = 80
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           dev_en,
   input  logic [NUM_SETS-1:0]            set_en,
   input  logic [1:0]                     fsel,
   input  logic                           force_off,
   input  logic [NUM_SETS*3*DUTY_W-1:0]   duty_in,
   input  logic [NUM_SETS*3*LVL_W-1:0]    lvl_in,
   output logic [NUM_SETS*3-1:0]          gate_out,
   output logic [NUM_SETS*3*LVL_W-1:0]    lvl_out
);
   localparam int STEPS = (1 << DUTY_W) - 1;

   generate
      if (DUTY_W < 2)
         $error("DUTY_W must be at least 2");
      if ((STEP_DIV % 4) != 0 || STEP_DIV < 8)
         $error("STEP_DIV must be a multiple of 4 and at least 8");
      if (SET_OFFSET < 1 || SET_OFFSET >= STEPS)
         $error("SET_OFFSET must lie inside one period");
   endgenerate

   logic              step_tick;
   logic [DUTY_W-1:0] step_idx;

   pwm_step_timer #(
      .STEP_DIV (STEP_DIV),
      .STEP_W   (DUTY_W),
      .STEPS    (STEPS)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .dev_en (dev_en),
      .fsel   (fsel),
      .tick   (step_tick),
      .step   (step_idx)
   );

   generate
      for (genvar k = 0; k < NUM_SETS; k++) begin : g_set
         pwm_set #(
            .IDX        (k),
            .DUTY_W     (DUTY_W),
            .STEPS      (STEPS),
            .SET_OFFSET (SET_OFFSET)
         ) u_set (
            .clk       (clk),
            .rst_n     (rst_n),
            .dev_en    (dev_en),
            .set_en    (set_en[k]),
            .force_off (force_off),
            .tick      (step_tick),
            .step      (step_idx),
            .duty_in   (duty_in[k*3*DUTY_W +: 3*DUTY_W]),
            .gate      (gate_out[k*3 +: 3])
         );
      end
   endgenerate

   assign lvl_out = lvl_in;
endmodule

// File: rtl/rgb_pwm_chk.sv
module rgb_pwm_chk #(
   parameter int NUM_SETS = 4,
   parameter int DUTY_W   = 6,
   parameter int LVL_W    = 2
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        dev_en,
   input logic                        force_off,
   input logic [NUM_SETS-1:0]         set_en,
   input logic [NUM_SETS*3*LVL_W-1:0] lvl_in,
   input logic [NUM_SETS*3*LVL_W-1:0] lvl_out,
   input logic [NUM_SETS*3-1:0]       gate_out,
   input logic                        step_tick,
   input logic [DUTY_W-1:0]           step_idx
);
   localparam int STEPS = (1 << DUTY_W) - 1;

   // R10
   force_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      force_off |-> gate_out == '0);

   // R8
   standby_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_en |-> gate_out == '0);

   generate
      for (genvar k = 0; k < NUM_SETS; k++) begin : g_sk
         // R8
         set_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !set_en[k] |-> gate_out[k*3 +: 3] == 3'b000);
      end
   endgenerate

   // R11
   lvl_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_out == lvl_in);

   // R6
   step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_idx < DUTY_W'(STEPS));

   // R6
   step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_tick |=> step_idx == (($past(step_idx) == DUTY_W'(STEPS - 1)) ? '0 : $past(step_idx) + 1'b1));

   // R9
   gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_en && $past(dev_en) && !$past(step_tick) && $stable(set_en) && $stable(force_off))
      |-> $stable(gate_out));
endmodule

bind rgb_pwm_stagger rgb_pwm_chk #(
   .NUM_SETS (NUM_SETS),
   .DUTY_W   (DUTY_W),
   .LVL_W    (LVL_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dev_en    (dev_en),
   .force_off (force_off),
   .set_en    (set_en),
   .lvl_in    (lvl_in),
   .lvl_out   (lvl_out),
   .gate_out  (gate_out),
   .step_tick (step_tick),
   .step_idx  (step_idx)
);

// File: tb/rgb_pwm_stagger_tb.sv
`timescale 1ns/1ps
module rgb_pwm_stagger_tb;
   localparam int DIV = 8;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        dev_en = 0;
   logic [3:0]  set_en = '0;
   logic [1:0]  fsel = '0;
   logic        force_off = 0;
   logic [71:0] duty_in = '0;
   logic [23:0] lvl_in = '0;
   logic [11:0] gate_out;
   logic [23:0] lvl_out;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   always #10 clk = ~clk;

   rgb_pwm_stagger #(.STEP_DIV(DIV)) u_dut (
      .clk(clk), .rst_n(rst_n), .dev_en(dev_en), .set_en(set_en), .fsel(fsel),
      .force_off(force_off), .duty_in(duty_in), .lvl_in(lvl_in),
      .gate_out(gate_out), .lvl_out(lvl_out));

   // fsel[19:18] set_en[17:14] base[13:7] stride[6:0]; duty(ch) = (base + stride*ch) mod 64
   localparam logic [19:0] VEC [5] = '{
      {2'b00, 4'hF, 7'd0,  7'd5},
      {2'b01, 4'hF, 7'd63, 7'd63},
      {2'b10, 4'h5, 7'd1,  7'd11},
      {2'b11, 4'hA, 7'd32, 7'd17},
      {2'b01, 4'hF, 7'd31, 7'd2}
   };

   task automatic check(input bit ok, input string tag, input string msg);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: %s", tag, msg);
      end
   endtask

   function automatic int step_len(input logic [1:0] fs);
      return fs[1] ? DIV / 4 : (fs[0] ? DIV / 2 : DIV);
   endfunction

   function automatic bit want_on(input int p, input int n, input int col);
      int s;
      if (col == 0) return p < n;
      if (col == 1) begin
         s = (63 - n) / 2;
         return (p >= s) && (p < s + n);
      end
      return p >= 63 - n;
   endfunction

   task automatic restart(input logic [1:0] fs, input logic [3:0] se);
      @(negedge clk);
      dev_en = 0;
      fsel = fs;
      set_en = se;
      repeat (2) @(negedge clk);
      dev_en = 1;
   endtask

   initial begin
      string ctag [3];
      ctag[0] = "R3"; ctag[1] = "R4"; ctag[2] = "R5";

      // R1: reset holds all gates off even with everything enabled
      dev_en = 1; set_en = 4'hF; duty_in = '1;
      repeat (3) @(negedge clk);
      #1 check(gate_out == '0, "R1", $sformatf("gate=%h exp=000", gate_out));
      dev_en = 0;
      @(negedge clk) rst_n = 1;

      // vector table: R2, R3, R4, R5, R6, R7
      foreach (VEC[v]) begin
         int mism [12];
         int cnt [12];
         int dty [12];
         int len;
         logic [3:0] se;
         se = VEC[v][17:14];
         for (int ch = 0; ch < 12; ch++) begin
            dty[ch] = (int'(VEC[v][13:7]) + int'(VEC[v][6:0]) * ch) % 64;
            duty_in[ch*6 +: 6] = 6'(dty[ch]);
            mism[ch] = 0; cnt[ch] = 0;
         end
         len = step_len(VEC[v][19:18]);
         restart(VEC[v][19:18], se);
         for (int g = 0; g < 63; g++) begin
            #1;
            for (int ch = 0; ch < 12; ch++) begin
               int k, p;
               bit e;
               k = ch / 3;
               p = (g - 16 * k + 63) % 63;
               e = se[k] && want_on(p, dty[ch], ch % 3);
               if (gate_out[ch] !== e) mism[ch]++;
               if (gate_out[ch]) cnt[ch]++;
            end
            repeat (len) @(negedge clk);
         end
         for (int ch = 0; ch < 12; ch++) begin
            int k;
            k = ch / 3;
            // R2 R6 R7 plus the colour window R3/R4/R5
            check(mism[ch] == 0 && cnt[ch] == (se[k] ? dty[ch] : 0), ctag[ch % 3],
                  $sformatf("R2/R6 vec %0d ch %0d: on=%0d mism=%0d exp on=%0d mism=0",
                            v, ch, cnt[ch], mism[ch], se[k] ? dty[ch] : 0));
         end
      end

      // R7: step length per frequency select, seen as red pulse of duty 1
      for (int fs = 0; fs < 4; fs++) begin
         int w;
         duty_in = '0;
         duty_in[5:0] = 6'd1;
         restart(2'(fs), 4'h1);
         w = 0;
         repeat (20) begin
            #1 if (gate_out[0]) w++;
            @(negedge clk);
         end
         check(w == step_len(2'(fs)), "R7",
               $sformatf("fsel=%0d width=%0d exp=%0d", fs, w, step_len(2'(fs))));
      end

      // R9: mid-period duty write applies from next period
      begin
         int on_old, on_new, mism_new;
         duty_in = '0;
         duty_in[5:0] = 6'd10;
         restart(2'b10, 4'hF);
         repeat (30 * 2) @(negedge clk);
         duty_in[5:0] = 6'd50;
         on_old = 0;
         for (int g = 30; g < 63; g++) begin
            #1 if (gate_out[0]) on_old++;
            repeat (2) @(negedge clk);
         end
         check(on_old == 0, "R9", $sformatf("old period tail on=%0d exp=0", on_old));
         on_new = 0; mism_new = 0;
         for (int g = 0; g < 63; g++) begin
            #1;
            if (gate_out[0]) on_new++;
            if (gate_out[0] !== (g < 50)) mism_new++;
            repeat (2) @(negedge clk);
         end
         check(on_new == 50 && mism_new == 0, "R9",
               $sformatf("new period on=%0d mism=%0d exp on=50 mism=0", on_new, mism_new));
      end

      // R2 full duty, R10 force-off, R8 gating
      duty_in = '1;
      restart(2'b10, 4'hF);
      @(negedge clk);
      #1 check(gate_out == 12'hFFF, "R2", $sformatf("gate=%h exp=fff", gate_out));
      force_off = 1;
      #1 check(gate_out == 12'h000, "R10", $sformatf("gate=%h exp=000", gate_out));
      force_off = 0;
      #1 check(gate_out == 12'hFFF, "R10", $sformatf("release gate=%h exp=fff", gate_out));
      set_en = 4'b1110;
      #1 check(gate_out == 12'hFF8, "R8", $sformatf("set0 off gate=%h exp=ff8", gate_out));
      set_en = 4'hF;
      dev_en = 0;
      #1 check(gate_out == 12'h000, "R8", $sformatf("standby gate=%h exp=000", gate_out));

      // R11: amplitude codes forwarded unchanged
      for (int i = 0; i < 3; i++) begin
         lvl_in = (i == 0) ? 24'hE4E4E4 : ((i == 1) ? 24'h1B2D36 : 24'hFFF000);
         #1 check(lvl_out == lvl_in, "R11", $sformatf("lvl_out=%h exp=%h", lvl_out, lvl_in));
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: run hung, actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule